// File: doc/BRIEF.md
# Cache Miss Type Classifier

This block watches a stream of byte-address references and labels each one as a hit, a cold miss, a conflict miss or a capacity miss. It runs two tag-only models side by side. The first is the cache under study, which is direct mapped. The second is a fully associative shadow with the same number of lines and least-recently-used replacement. A one-bit-per-block record of every block touched since reset marks first-time references.

A reference that hits in the direct-mapped model is a hit. A miss on a block that was never touched is cold. A repeat miss that the shadow would have served is a conflict miss, because only the fixed placement caused it. Any other repeat miss is a capacity miss. No data is stored and no memory traffic is produced. Four saturating counters accumulate the classes, which lets a trace be profiled in hardware.

Top module: `miss_classifier`

## Requirements
- R1: While and after reset, `res_valid` is 0, all four counters are 0 and both models and the seen record are empty, so the first reference to any block is classified cold.
- R2: A result appears exactly one cycle after its request: `res_valid` equals the previous cycle's `req_valid`. A cycle with `req_valid` low produces no result and changes no state, whatever `req_addr` holds.
- R3: A reference whose block is resident in its direct-mapped line gives class 2'b00 (hit).
- R4: A miss on a block not referenced since reset gives class 2'b01 (cold).
- R5: A miss on a previously referenced block that is resident in the fully associative shadow gives class 2'b10 (conflict).
- R6: A miss on a previously referenced block that is absent from the shadow gives class 2'b11 (capacity).
- R7: With default parameters, block = `req_addr[4:1]`, line index = block bits [1:0] and tag = block bits [3:2]. The offset bit `req_addr[0]` does not affect hit detection.
- R8: The shadow holds 4 blocks and, when full, replaces the least recently referenced one. Every reference, including a direct-mapped hit, refreshes the shadow. A direct-mapped hit is reported as a hit even when the shadow would have missed.
- R9: Each counter (`hit_count`, `cold_count`, `conflict_count`, `capacity_count`) increases by one for each result of its class and holds at 2^CNT_W-1 once it gets there.
- R10: The 16-reference trace 0,16,1,17,...,7,23 classifies as cold,cold,conflict,conflict repeated four times. A following reference to address 0 is then capacity, and a reference to address 1 right after it is a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Reference strobe |
| req_addr | input | ADDR_W | Byte address of the reference |
| res_valid | output | 1 | Classification valid, one cycle after the request |
| res_class | output | 2 | 00 hit, 01 cold, 10 conflict, 11 capacity |
| hit_count | output | CNT_W | Saturating count of hits |
| cold_count | output | CNT_W | Saturating count of cold misses |
| conflict_count | output | CNT_W | Saturating count of conflict misses |
| capacity_count | output | CNT_W | Saturating count of capacity misses |

## Verification
The two functions that can coincide are a direct-mapped hit and a shadow replacement. Both can happen in the same cycle when the shadow has already aged out a block that the direct-mapped model still holds. The bench sets this up with references to blocks 0, 1, 2, 3 and 5, then references block 0 again. That reference must report a hit, and it must also pull block 0 back into the shadow and evict block 1. The bench judges the eviction at the ports: the next reference to block 1 must come out as capacity, not conflict.

// File: rtl/miss_classifier.sv
module miss_classifier #(
  parameter int ADDR_W = 5,
  parameter int OFS_W  = 1,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              res_valid,
  output logic [1:0]        res_class,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  cold_count,
  output logic [CNT_W-1:0]  conflict_count,
  output logic [CNT_W-1:0]  capacity_count
);
  localparam int BLK_W = ADDR_W - OFS_W;
  localparam int TAG_W = BLK_W - IDX_W;
  localparam int LINES = 1 << IDX_W;
  localparam int NBLK  = 1 << BLK_W;
  localparam logic [1:0] C_HIT = 2'b00, C_COLD = 2'b01, C_CONF = 2'b10, C_CAP = 2'b11;

  wire [BLK_W-1:0] blk = req_addr[ADDR_W-1:OFS_W];
  wire [IDX_W-1:0] idx = blk[IDX_W-1:0];
  wire [TAG_W-1:0] tag = blk[BLK_W-1:IDX_W];
  wire unused_ofs = ^req_addr[OFS_W-1:0];

  logic [LINES-1:0] dm_v;
  logic [TAG_W-1:0] dm_tag [LINES];
  logic [NBLK-1:0]  seen;
  logic [LINES-1:0] fa_v;
  logic [BLK_W-1:0] fa_blk [LINES];
  logic [IDX_W-1:0] fa_age [LINES];
  logic [CNT_W-1:0] cnt [4];

  logic             fa_hit;
  logic [IDX_W-1:0] hit_way, old_way, ref_way, ref_age;
  logic [1:0]       cls;

  always_comb begin
    fa_hit  = 1'b0;
    hit_way = '0;
    old_way = '0;
    for (int i = 0; i < LINES; i++) begin
      if (fa_v[i] && fa_blk[i] == blk) begin
        fa_hit  = 1'b1;
        hit_way = IDX_W'(i);
      end
      if (fa_age[i] == IDX_W'(LINES - 1)) old_way = IDX_W'(i);
    end
  end

  assign ref_way = fa_hit ? hit_way : old_way;
  assign ref_age = fa_age[ref_way];

  wire dm_hit = dm_v[idx] && (dm_tag[idx] == tag);
  assign cls = dm_hit     ? C_HIT  :
               !seen[blk] ? C_COLD :
               fa_hit     ? C_CONF : C_CAP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_class <= C_HIT;
      dm_v      <= '0;
      seen      <= '0;
      fa_v      <= '0;
      for (int i = 0; i < LINES; i++) begin
        dm_tag[i] <= '0;
        fa_blk[i] <= '0;
        fa_age[i] <= IDX_W'(LINES - 1 - i);
      end
      for (int c = 0; c < 4; c++) cnt[c] <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_class   <= cls;
        dm_v[idx]   <= 1'b1;
        dm_tag[idx] <= tag;
        seen[blk]   <= 1'b1;
        for (int i = 0; i < LINES; i++) begin
          if (IDX_W'(i) == ref_way) begin
            fa_v[i]   <= 1'b1;
            fa_blk[i] <= blk;
            fa_age[i] <= '0;
          end else if (fa_age[i] < ref_age) begin
            fa_age[i] <= fa_age[i] + 1'b1;
          end
        end
        if (cnt[cls] != '1) cnt[cls] <= cnt[cls] + 1'b1;
      end
    end
  end

  assign hit_count      = cnt[0];
  assign cold_count     = cnt[1];
  assign conflict_count = cnt[2];
  assign capacity_count = cnt[3];
endmodule

// File: rtl/miss_classifier_chk.sv
module miss_classifier_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             res_valid,
  input logic [1:0]       res_class,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] cold_count,
  input logic [CNT_W-1:0] conflict_count,
  input logic [CNT_W-1:0] capacity_count
);
  // R2
  res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  // R2
  no_req_no_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  // R9
  hit_cnt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count != $past(hit_count)) |-> (res_valid && res_class == 2'b00));
  // R9
  cold_cnt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cold_count != $past(cold_count)) |-> (res_valid && res_class == 2'b01));
  // R9
  conf_cnt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_count != $past(conflict_count)) |-> (res_valid && res_class == 2'b10));
  // R9
  cap_cnt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capacity_count != $past(capacity_count)) |-> (res_valid && res_class == 2'b11));
  // R9
  hit_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hit_count) == {CNT_W{1'b1}}) |-> (hit_count == {CNT_W{1'b1}}));
  // R9
  one_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit_count != $past(hit_count), cold_count != $past(cold_count),
                conflict_count != $past(conflict_count),
                capacity_count != $past(capacity_count)}) <= 1);
endmodule

bind miss_classifier miss_classifier_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .res_valid(res_valid),
  .res_class(res_class), .hit_count(hit_count), .cold_count(cold_count),
  .conflict_count(conflict_count), .capacity_count(capacity_count));

// File: tb/tb_miss_classifier.sv
module tb_miss_classifier;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [4:0] req_addr = '0;
  logic       res_valid;
  logic [1:0] res_class;
  logic [7:0] hit_count, cold_count, conflict_count, capacity_count;
  int checks = 0, failures = 0;
  bit done = 0;

  miss_classifier dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .res_valid(res_valid), .res_class(res_class), .hit_count(hit_count),
    .cold_count(cold_count), .conflict_count(conflict_count),
    .capacity_count(capacity_count));

  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ref_addr(logic [4:0] a, logic [1:0] exp, string req);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " res_valid"}, res_valid, 1);
    check({req, " class"}, res_class, exp);
  endtask

  task automatic counts(string req, int h, int co, int cf, int cp);
    check({req, " hit_count"}, hit_count, h);
    check({req, " cold_count"}, cold_count, co);
    check({req, " conflict_count"}, conflict_count, cf);
    check({req, " capacity_count"}, capacity_count, cp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 res_valid in reset", res_valid, 0);
    counts("R1", 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 res_valid after reset", res_valid, 0);
  endtask

  task automatic t_trace();
    do_reset();
    for (int n = 0; n < 16; n++) begin
      logic [4:0] a = (n % 2 == 0) ? 5'(n / 2) : 5'(16 + n / 2);
      ref_addr(a, (n % 4 < 2) ? 2'b01 : 2'b10, "R10 R4 R5 trace");
    end
    ref_addr(5'd0, 2'b11, "R10 R6 capacity after trace");
    ref_addr(5'd1, 2'b00, "R10 R3 R7 hit other offset");
    counts("R10 R9", 1, 8, 8, 1);
  endtask

  task automatic t_idle();
    do_reset();
    ref_addr(5'd0, 2'b01, "R2 first cold");
    @(negedge clk);
    req_addr = 5'd16;
    @(negedge clk);
    check("R2 no result when idle", res_valid, 0);
    req_addr = 5'd2;
    @(negedge clk);
    check("R2 no result when idle", res_valid, 0);
    ref_addr(5'd0, 2'b00, "R2 idle address did not evict");
    ref_addr(5'd2, 2'b01, "R2 idle address not marked seen");
    counts("R2", 1, 2, 0, 0);
  endtask

  task automatic t_offset();
    do_reset();
    ref_addr(5'd4, 2'b01, "R7 block 2 cold");
    ref_addr(5'd5, 2'b00, "R7 offset bit ignored");
    ref_addr(5'd12, 2'b01, "R7 block 6 same index cold");
    ref_addr(5'd4, 2'b10, "R7 R5 same index conflict");
    ref_addr(5'd13, 2'b10, "R7 R5 tag compare conflict");
  endtask

  task automatic t_hit_vs_shadow();
    do_reset();
    ref_addr(5'd0, 2'b01, "R8 blk0");
    ref_addr(5'd2, 2'b01, "R8 blk1");
    ref_addr(5'd4, 2'b01, "R8 blk2");
    ref_addr(5'd6, 2'b01, "R8 blk3");
    ref_addr(5'd10, 2'b01, "R8 blk5");
    ref_addr(5'd0, 2'b00, "R8 R3 hit despite shadow eviction");
    ref_addr(5'd2, 2'b11, "R8 R6 hit refreshed shadow, LRU evicted");
    ref_addr(5'd6, 2'b00, "R8 blk3 still resident");
  endtask

  task automatic t_saturate();
    do_reset();
    ref_addr(5'd8, 2'b01, "R9 cold");
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_addr = 5'd9;
    end
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    counts("R9 saturation", 255, 1, 0, 0);
    ref_addr(5'd8, 2'b00, "R9 R3 hit after saturation");
    check("R9 hit_count held", hit_count, 255);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_trace();
    t_idle();
    t_offset();
    t_hit_vs_shadow();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule